// File: doc/BRIEF.md
# Reset configuration word fetcher

After a hard reset, this block reads eight 32-bit configuration words out of a boot memory that is only read one byte at a time. It makes 32 single-byte reads. The read addresses start at zero and advance by eight, so every read falls on a 64-bit boundary. Only the lowest byte lane of the returned data is used, so the port width of the boot device does not matter.

Each group of four reads is packed into one word, with the earliest byte placed at the top. The first word belongs to the local device. The block exposes that word and decodes from it the exception-prefix bit and the reset vector address that the bit selects. The remaining seven words are placed, in order, on a flat output bus for configuration slaves one to seven.

A done flag rises once the last byte has been captured. It stays high until the next reset, and all word outputs read zero until it rises.

Top module: `cfg_word_fetch`

## Requirements
- R1: Once reset is released, `rd_req` is high and `rd_addr` is 0.
- R2: Exactly 32 reads are made. Each accepted read (a cycle with `rd_req` and `rd_ack` both high) moves `rd_addr` up by 8, so read n uses address 8*n.
- R3: While `rd_req` is high and `rd_ack` is low, `rd_req` stays high and `rd_addr` does not change.
- R4: Only bits [7:0] of `rd_data` are captured. Higher bits have no effect on any output.
- R5: Read 4k+j supplies bits [31-8j -: 8] of word k. Word 0 appears on `master_word`. Word k, for k = 1 to 7, appears on `slave_words[32*(k-1) +: 32]`.
- R6: `done` rises in the cycle after the 32nd accepted read. It then stays high and `rd_req` stays low until reset. Any `rd_ack` seen after that has no effect on the outputs.
- R7: While `done` is low, `master_word`, `slave_words`, `prefix_bit` and `reset_vector` are all zero.
- R8: `prefix_bit` is the bit of the master word at position PFX_POS counted from the MSB. With the default of 20, that is bit 11. When `done` is high, `reset_vector` is 0xFFF00100 if `prefix_bit` is 1 and 0x00000100 if it is 0.
- R9: An active-low asynchronous reset clears the read counter, all word registers and `done`, so `rd_addr` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | output | 1 | Read request to the boot memory |
| rd_addr | output | ADDR_W | Byte address of the current read |
| rd_ack | input | 1 | Read acknowledge; data is valid in this cycle |
| rd_data | input | BUS_W | Read data; only bits [7:0] are used |
| done | output | 1 | All 32 bytes captured |
| master_word | output | 32 | Configuration word of the local device |
| prefix_bit | output | 1 | Decoded exception-prefix bit |
| reset_vector | output | 32 | Reset exception address chosen by the prefix bit |
| slave_words | output | 224 | Words for slaves 1..7, slave 1 in the low 32 bits |

## Verification
The assertions assume the memory raises `rd_ack` only in answer to a live `rd_req`, and that it returns the byte in that same cycle. They also assume reset is held for at least one clock edge.

The bench's memory model answers only while a request is pending, and it uses both random wait states and back-to-back acknowledges. After `done` it also sends stray acknowledges. Those fall outside the request protocol but are allowed by R6, and the bench confirms at the outputs that they change nothing.

// File: rtl/cfw_pkg.sv
package cfw_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;

  // Reset vector address for a given prefix value.
  function automatic logic [WORD_W-1:0] vector_for(input logic pfx,
                                                   input logic [WORD_W-1:0] hi_base,
                                                   input logic [WORD_W-1:0] offs);
    return (pfx ? hi_base : '0) + offs;
  endfunction

  // Byte address of read number n.
  function automatic int unsigned read_addr(input int unsigned n, input int unsigned stride);
    return n * stride;
  endfunction
endpackage

// File: rtl/cfw_seq.sv
module cfw_seq #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_READS = 32,
  parameter int unsigned STRIDE    = 8,
  localparam int unsigned IDX_W    = $clog2(NUM_READS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_ack,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              take,
  output logic [IDX_W-1:0]  take_idx,
  output logic              done
);
  logic [IDX_W-1:0] idx;
  logic             last;

  assign rd_req   = !done;
  assign take     = rd_req && rd_ack;
  assign take_idx = idx;
  assign last     = (idx == IDX_W'(NUM_READS - 1));
  assign rd_addr  = ADDR_W'(cfw_pkg::read_addr(int'(idx), STRIDE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      done <= 1'b0;
    end else if (take) begin
      if (last) done <= 1'b1;
      else      idx  <= idx + 1'b1;
    end
  end

  a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    take && !last |=> rd_addr == $past(rd_addr) + ADDR_W'(STRIDE));
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && !rd_req);
  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    take && last |=> $rose(done));
endmodule

// File: rtl/cfw_pack.sv
module cfw_pack #(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned BPW       = 4,
  parameter int unsigned IDX_W     = 5,
  localparam int unsigned WORD_W   = cfw_pkg::WORD_W,
  localparam int unsigned BYTE_W   = cfw_pkg::BYTE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          take,
  input  logic [IDX_W-1:0]              take_idx,
  input  logic [BYTE_W-1:0]             byte_in,
  output logic [NUM_WORDS*WORD_W-1:0]   words
);
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    for (genvar b = 0; b < BPW; b++) begin : g_byte
      logic hit;
      assign hit = take && (take_idx == IDX_W'(g*BPW + b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   words[g*WORD_W + WORD_W-1-BYTE_W*b -: BYTE_W] <= '0;
        else if (hit) words[g*WORD_W + WORD_W-1-BYTE_W*b -: BYTE_W] <= byte_in;
      end
    end
  end

  a_r5_hold_without_take: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(words));
endmodule

// File: rtl/cfw_decode.sv
module cfw_decode #(
  parameter int unsigned PFX_POS  = 20,
  parameter logic [31:0] HI_BASE  = 32'hFFF0_0000,
  parameter logic [31:0] VEC_OFF  = 32'h0000_0100,
  localparam int unsigned WORD_W  = cfw_pkg::WORD_W,
  localparam int unsigned PFX_BIT = WORD_W - 1 - PFX_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [WORD_W-1:0] word0,
  output logic              prefix_bit,
  output logic [WORD_W-1:0] reset_vector
);
  assign prefix_bit   = done && word0[PFX_BIT];
  assign reset_vector = done ? cfw_pkg::vector_for(prefix_bit, HI_BASE, VEC_OFF) : '0;

  a_r8_high_base: assert property (@(posedge clk) disable iff (!rst_n)
    done && prefix_bit |-> reset_vector - VEC_OFF == HI_BASE);
  a_r8_low_base: assert property (@(posedge clk) disable iff (!rst_n)
    done && !prefix_bit |-> reset_vector == VEC_OFF);
endmodule

// File: rtl/cfg_word_fetch.sv
module cfg_word_fetch #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BUS_W     = 64,
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned BPW       = 4,
  parameter int unsigned STRIDE    = 8,
  parameter int unsigned PFX_POS   = 20,
  localparam int unsigned WORD_W   = cfw_pkg::WORD_W,
  localparam int unsigned NUM_READS = NUM_WORDS * BPW,
  localparam int unsigned IDX_W    = $clog2(NUM_READS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  output logic                            rd_req,
  output logic [ADDR_W-1:0]               rd_addr,
  input  logic                            rd_ack,
  input  logic [BUS_W-1:0]                rd_data,
  output logic                            done,
  output logic [WORD_W-1:0]               master_word,
  output logic                            prefix_bit,
  output logic [WORD_W-1:0]               reset_vector,
  output logic [(NUM_WORDS-1)*WORD_W-1:0] slave_words
);
  logic                        take;
  logic [IDX_W-1:0]            take_idx;
  logic [NUM_WORDS*WORD_W-1:0] words;

  cfw_seq #(.ADDR_W(ADDR_W), .NUM_READS(NUM_READS), .STRIDE(STRIDE)) u_seq (
    .clk(clk), .rst_n(rst_n), .rd_ack(rd_ack), .rd_req(rd_req), .rd_addr(rd_addr),
    .take(take), .take_idx(take_idx), .done(done));

  cfw_pack #(.NUM_WORDS(NUM_WORDS), .BPW(BPW), .IDX_W(IDX_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .take_idx(take_idx),
    .byte_in(rd_data[cfw_pkg::BYTE_W-1:0]), .words(words));

  assign master_word = done ? words[WORD_W-1:0] : '0;
  assign slave_words = done ? words[NUM_WORDS*WORD_W-1:WORD_W] : '0;

  cfw_decode #(.PFX_POS(PFX_POS)) u_dec (
    .clk(clk), .rst_n(rst_n), .done(done), .word0(words[WORD_W-1:0]),
    .prefix_bit(prefix_bit), .reset_vector(reset_vector));

  a_r7_zero_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> master_word == '0 && slave_words == '0 && reset_vector == '0);
  a_r1_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> rd_req && rd_addr == '0);
endmodule

// File: tb/cfg_word_fetch_tb.sv
module cfg_word_fetch_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_req;
  logic [15:0]  rd_addr;
  logic         rd_ack = 1'b0;
  logic [63:0]  rd_data = '0;
  logic         done;
  logic [31:0]  master_word;
  logic         prefix_bit;
  logic [31:0]  reset_vector;
  logic [223:0] slave_words;

  int checks = 0;
  int fails  = 0;
  int run    = 0;
  int idx    = 0;
  int waitc  = 0;
  int cyc    = 0;
  bit hs_prev = 1'b0;

  always #2.5 clk = ~clk;

  cfg_word_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .done(done), .master_word(master_word), .prefix_bit(prefix_bit),
    .reset_vector(reset_vector), .slave_words(slave_words));

  function automatic logic [7:0] pat(input int r, input int n);
    logic [7:0] v;
    v = 8'((n * 37 + r * 91 + 13) ^ (n << 4));
    if (n == 2) v[3] = (r != 0);
    return v;
  endfunction

  function automatic logic [31:0] exp_word(input int r, input int k);
    return {pat(r, 4*k), pat(r, 4*k+1), pat(r, 4*k+2), pat(r, 4*k+3)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      idx = 0; hs_prev = 1'b0; rd_ack = 1'b0; waitc = 0;
      check("R9 done cleared", 64'(done), 64'd0);
      check("R9 addr cleared", 64'(rd_addr), 64'd0);
      check("R9 master cleared", 64'(master_word), 64'd0);
    end else begin
      if (hs_prev) idx++;
      check(idx == 0 ? "R1 req" : "R2 req", 64'(rd_req), 64'(idx < 32));
      if (idx < 32) begin
        check(idx == 0 ? "R1 addr" : "R2/R3 addr", 64'(rd_addr), 64'(idx * 8));
        check("R6 done low", 64'(done), 64'd0);
        check("R7 master zero", 64'(master_word), 64'd0);
        check("R7 slaves zero", 64'(slave_words != '0), 64'd0);
        check("R7 vector zero", 64'({prefix_bit, reset_vector}), 64'd0);
      end else begin
        check("R6 done high", 64'(done), 64'd1);
        check("R5 master word", 64'(master_word), 64'(exp_word(run, 0)));
        for (int k = 1; k < 8; k++)
          check("R5 slave word", 64'(slave_words[32*(k-1) +: 32]), 64'(exp_word(run, k)));
        check("R8 prefix", 64'(prefix_bit), 64'(exp_word(run, 0)[11]));
        check("R8 vector", 64'(reset_vector),
              64'(exp_word(run, 0)[11] ? 32'hFFF0_0100 : 32'h0000_0100));
      end
      // memory model: R4 junk on upper lanes
      if (rd_req && waitc == 0) begin
        rd_ack  = 1'b1;
        rd_data = {{7{~pat(run, int'(rd_addr) / 8)}}, pat(run, int'(rd_addr) / 8)};
        waitc   = (run == 0) ? (idx * 5 + cyc) % 3 : 0;
      end else if (!rd_req && (cyc % 2 == 0)) begin
        rd_ack  = 1'b1;            // R6 stray ack after done
        rd_data = 64'hFFFF_FFFF_FFFF_FFFF;
      end else begin
        rd_ack = 1'b0;
        if (waitc > 0) waitc--;
      end
      hs_prev = rd_req && rd_ack;
    end
  end

  initial begin
    run = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    wait (done === 1'b1);
    repeat (20) @(posedge clk);
    // run 1: reset partway through (R9)
    #1 rst_n = 1'b0; run = 1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (12) @(posedge clk);
    #1 rst_n = 1'b0; run = 2;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    wait (done === 1'b1);
    repeat (20) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule